// File: doc/BRIEF.md
# CPU Clock Source and Ratio Controller

This block chooses the clock that drives the processor core. It can take either a fast main oscillator, passed straight through or divided down, or a slow sub oscillator. Software writes a six-bit control word through a simple write port. The block reads that word back unchanged, apart from the bits its protection rules override. From the word it derives the active clock, the enables for both oscillators, and a three-bit mode code.

Moving from one source to the other happens in two steps. First the block waits for the target oscillator's stable flag. Then a falling-edge handshake removes the old clock before the new one is let through. When the main oscillator is stopped while the core runs from the sub clock, the block enters its lowest-power state. In that state the divide-by-8 bit is pinned on, so the next return to the main clock begins at a ratio of eight.

Top module: `cmc_top`

## Requirements
- R1: After reset the control word reads 0x02: bit 1 (divide-by-8) is 1 and every other bit is 0. The mode code is 3, the main oscillator enable is 1 and the sub oscillator enable is 0.
- R2: Control bit 0 (sub select) = 0, bit 1 = 0 and field bits 3:2 = 00 run the core at the main clock rate. The mode code is then 0.
- R3: Bit 1 = 0 with bits 3:2 = 01, 10 or 11 divides the main clock by 2, 4 or 16 respectively. The matching mode codes are 1, 2 and 4.
- R4: Bit 1 = 1 divides the main clock by 8 whatever bits 3:2 hold, and the mode code is 3.
- R5: Bit 0 = 1 runs the core from the sub clock and gives mode code 5. Bit 5 drives the sub oscillator enable.
- R6: A change of bit 0 takes effect, as seen in the mode code, only in the cycle after the target oscillator's stable input is seen high. Until then the old source stays in use.
- R7: Writing bit 4 (main off) as 1 while the core runs from the sub clock, with bit 0 written as 1, enters low-power mode (code 6). In that same write, bit 1 becomes 1 and the main oscillator enable drops to 0.
- R8: While bit 4 reads 1, writes to bit 1 have no effect.
- R9: While bit 4 reads 1, a write of bit 0 as 0 is rejected and bit 0 stays 1.
- R10: A write of bit 4 as 1 is ignored unless the core is already running from the sub clock.
- R11: No high or low phase of the core clock is shorter than a half period of the faster source, including during a source change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Fast oscillator clock |
| sub_clk | input | 1 | Slow oscillator clock |
| main_stable | input | 1 | Fast oscillator is stable |
| sub_stable | input | 1 | Slow oscillator is stable |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 6 | Control word to write |
| rd_data | output | 6 | Control word read-back |
| cpu_clk | output | 1 | Selected core clock |
| main_osc_en | output | 1 | Fast oscillator enable |
| sub_osc_en | output | 1 | Slow oscillator enable |
| mode | output | 3 | Encoded operating mode |

## Verification
The bench builds the block with its defaults: a four-bit main divider counter and two-stage synchronisers. With these values every main ratio up to 16 is reachable, and the source handshake runs at the depth a real chip would use. Rate checks count core clock edges over a fixed window. A pulse-width monitor runs across each source change, so both directions of the handshake are exercised. These include the return from low-power, which must come back at a ratio of eight.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int CTRL_W = 6;
  localparam int B_SUB_SEL  = 0;
  localparam int B_DIV8     = 1;
  localparam int B_MAIN_OFF = 4;
  localparam int B_SUB_EN   = 5;

  typedef struct packed {
    logic       sub_en;
    logic       main_off;
    logic [1:0] div_fld;
    logic       div8;
    logic       sub_sel;
  } cmc_ctrl_t;

  typedef enum logic [2:0] {
    MODE_HIGH   = 3'd0,
    MODE_DIV2   = 3'd1,
    MODE_DIV4   = 3'd2,
    MODE_DIV8   = 3'd3,
    MODE_DIV16  = 3'd4,
    MODE_LOW    = 3'd5,
    MODE_LOWPWR = 3'd6
  } cmc_mode_e;
endpackage

// File: rtl/cmc_rst_sync.sv
module cmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cmc_ctrl_regs.sv
module cmc_ctrl_regs
  import cmc_pkg::*;
#(
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  cmc_ctrl_t       wr_data,
  input  logic            main_stable,
  input  logic            sub_stable,
  output cmc_ctrl_t       ctrl_q,
  output logic            use_sub,
  output cmc_mode_e       mode,
  output logic [SELW-1:0] div_log2
);
  cmc_ctrl_t ctrl_d;
  logic      use_sub_q, use_sub_d;
  logic      target_ok;

  always_comb begin
    ctrl_d    = ctrl_q;
    use_sub_d = use_sub_q;
    target_ok = ctrl_q.sub_sel ? sub_stable : main_stable;
    if ((ctrl_q.sub_sel != use_sub_q) && target_ok) use_sub_d = ctrl_q.sub_sel;
    if (wr_en) begin
      ctrl_d.sub_en  = wr_data.sub_en;
      ctrl_d.div_fld = wr_data.div_fld;
      if (!ctrl_q.main_off) ctrl_d.div8 = wr_data.div8;
      if (!(ctrl_q.main_off && !wr_data.sub_sel)) ctrl_d.sub_sel = wr_data.sub_sel;
      if (wr_data.main_off && !ctrl_q.main_off) begin
        if (use_sub_q && ctrl_q.sub_sel && wr_data.sub_sel) begin
          ctrl_d.main_off = 1'b1;
          ctrl_d.div8     = 1'b1;
        end
      end else if (!wr_data.main_off) begin
        ctrl_d.main_off = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '{sub_en: 1'b0, main_off: 1'b0, div_fld: 2'b00, div8: 1'b1, sub_sel: 1'b0};
      use_sub_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      use_sub_q <= use_sub_d;
    end
  end

  assign use_sub = use_sub_q;

  always_comb begin
    if (use_sub_q)        mode = ctrl_q.main_off ? MODE_LOWPWR : MODE_LOW;
    else if (ctrl_q.div8) mode = MODE_DIV8;
    else begin
      unique case (ctrl_q.div_fld)
        2'b00:   mode = MODE_HIGH;
        2'b01:   mode = MODE_DIV2;
        2'b10:   mode = MODE_DIV4;
        default: mode = MODE_DIV16;
      endcase
    end
  end

  always_comb begin
    if (ctrl_q.div8) div_log2 = SELW'(3);
    else begin
      unique case (ctrl_q.div_fld)
        2'b00:   div_log2 = SELW'(0);
        2'b01:   div_log2 = SELW'(1);
        2'b10:   div_log2 = SELW'(2);
        default: div_log2 = SELW'(4);
      endcase
    end
  end
endmodule

// File: rtl/cmc_main_div.sv
module cmc_main_div #(
  parameter int LOG2_MAX    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SELW        = 3
) (
  input  logic            main_clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] div_log2,
  output logic            clk_div
);
  localparam int SHW = SYNC_STAGES * SELW;

  logic [SHW-1:0]      sel_sh_q, sel_sh_d;
  logic [SELW-1:0]     sel;
  logic [LOG2_MAX-1:0] cnt_q, cnt_d;

  always_comb begin
    sel_sh_d = {sel_sh_q[SHW-SELW-1:0], div_log2};
    cnt_d    = cnt_q + 1'b1;
  end

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh_q <= '0;
      cnt_q    <= '0;
    end else begin
      sel_sh_q <= sel_sh_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sel = sel_sh_q[SHW-1 -: SELW];

  always_comb begin
    clk_div = main_clk;
    for (int i = 1; i <= LOG2_MAX; i++) begin
      if (sel == SELW'(i)) clk_div = cnt_q[i-1];
    end
  end
endmodule

// File: rtl/cmc_clk_switch.sv
module cmc_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_main,
  input  logic clk_sub,
  input  logic rst_n,
  input  logic sel_sub,
  output logic clk_out
);
  logic [1:0] src_clk, req, en;

  assign src_clk = {clk_sub, clk_main};
  assign req[0]  = ~sel_sub & ~en[1];
  assign req[1]  =  sel_sub & ~en[0];

  for (genvar g = 0; g < 2; g++) begin : g_branch
    logic [SYNC_STAGES-1:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[SYNC_STAGES-2:0], req[g]};

    always_ff @(negedge src_clk[g] or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign en[g] = sh_q[SYNC_STAGES-1];
  end

  assign clk_out = |(src_clk & en);
endmodule

// File: rtl/cmc_top.sv
module cmc_top
  import cmc_pkg::*;
#(
  parameter int DIV_LOG2_MAX = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_clk,
  input  logic              sub_clk,
  input  logic              main_stable,
  input  logic              sub_stable,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              cpu_clk,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic [2:0]        mode
);
  localparam int SELW = $clog2(DIV_LOG2_MAX + 1);

  logic            rst_n_sync;
  cmc_ctrl_t       ctrl;
  cmc_mode_e       mode_e;
  logic            use_sub;
  logic [SELW-1:0] div_log2;
  logic            main_div_clk;

  cmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  cmc_ctrl_regs #(.SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_data(cmc_ctrl_t'(wr_data)),
    .main_stable(main_stable), .sub_stable(sub_stable),
    .ctrl_q(ctrl), .use_sub(use_sub), .mode(mode_e), .div_log2(div_log2)
  );

  cmc_main_div #(.LOG2_MAX(DIV_LOG2_MAX), .SYNC_STAGES(SYNC_STAGES), .SELW(SELW)) u_div (
    .main_clk(main_clk), .rst_n(rst_n), .div_log2(div_log2), .clk_div(main_div_clk)
  );

  cmc_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
    .clk_main(main_div_clk), .clk_sub(sub_clk), .rst_n(rst_n),
    .sel_sub(use_sub), .clk_out(cpu_clk)
  );

  assign rd_data     = ctrl;
  assign main_osc_en = ~ctrl.main_off;
  assign sub_osc_en  = ctrl.sub_en;
  assign mode        = mode_e;
endmodule

// File: rtl/cmc_checks.sv
module cmc_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] rd_data,
  input logic [2:0] mode,
  input logic       main_osc_en,
  input logic       main_stable,
  input logic       sub_stable
);
  AST_LOWPWR_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6) |-> !main_osc_en); // R7
  AST_OFF_PINS_DIV8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[cmc_pkg::B_MAIN_OFF] |-> rd_data[cmc_pkg::B_DIV8]); // R8
  AST_OFF_KEEPS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[cmc_pkg::B_MAIN_OFF] |-> rd_data[cmc_pkg::B_SUB_SEL]); // R9
  AST_TO_SUB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd5 && $past(mode) < 3'd5) |-> $past(sub_stable)); // R6
  AST_TO_MAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < 3'd5 && $past(mode) >= 3'd5) |-> $past(main_stable)); // R6
  AST_OFF_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[cmc_pkg::B_MAIN_OFF]) |-> ($past(mode) == 3'd5)); // R10
endmodule

bind cmc_top cmc_checks u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .mode(mode),
  .main_osc_en(main_osc_en), .main_stable(main_stable), .sub_stable(sub_stable)
);

// File: tb/cmc_top_bench.sv
`timescale 1ns/1ps
module cmc_top_bench;
  logic       clk = 1'b0, main_clk = 1'b0, sub_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_stable = 1'b1, sub_stable = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [5:0] rd_data;
  logic       cpu_clk, main_osc_en, sub_osc_en;
  logic [2:0] mode;

  always #2.5 clk = ~clk;
  always #5   main_clk = ~main_clk;
  always #30  sub_clk = ~sub_clk;

  cmc_top u_cmc_top (
    .clk(clk), .rst_n(rst_n), .main_clk(main_clk), .sub_clk(sub_clk),
    .main_stable(main_stable), .sub_stable(sub_stable), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cpu_clk(cpu_clk), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .mode(mode)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;
  bit    done = 0;

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_near(string req, int act, int exp, string what);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d+-1", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_ss, m_d8, m_f, m_mo, m_se, m_use;
  int n_ss, n_d8, n_f, n_mo, n_se, n_use;
  int w_ss, w_d8, w_f, w_mo, w_se;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ss = 0; m_d8 = 1; m_f = 0; m_mo = 0; m_se = 0; m_use = 0;
    end else begin
      n_ss = m_ss; n_d8 = m_d8; n_f = m_f; n_mo = m_mo; n_se = m_se; n_use = m_use;
      if (m_ss != m_use && (m_ss == 1 ? sub_stable : main_stable)) n_use = m_ss;
      if (wr_en) begin
        w_ss = int'(wr_data[0]); w_d8 = int'(wr_data[1]); w_f = int'(wr_data[3:2]);
        w_mo = int'(wr_data[4]); w_se = int'(wr_data[5]);
        n_se = w_se; n_f = w_f;
        if (m_mo == 0) n_d8 = w_d8;
        if (!(m_mo == 1 && w_ss == 0)) n_ss = w_ss;
        if (w_mo == 1 && m_mo == 0) begin
          if (m_use == 1 && m_ss == 1 && w_ss == 1) begin n_mo = 1; n_d8 = 1; end
        end else if (w_mo == 0) n_mo = 0;
      end
      m_ss = n_ss; m_d8 = n_d8; m_f = n_f; m_mo = n_mo; m_se = n_se; m_use = n_use;
    end
  end

  function automatic int exp_mode();
    if (m_use == 1) return (m_mo == 1) ? 6 : 5;
    if (m_d8 == 1) return 3;
    case (m_f)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(cur_req, int'(rd_data), m_se*32 + m_mo*16 + m_f*4 + m_d8*2 + m_ss, "model rd_data");
      check(cur_req, int'(mode), exp_mode(), "model mode");
      check(cur_req, int'(main_osc_en), 1 - m_mo, "model main_osc_en");
      check(cur_req, int'(sub_osc_en), m_se, "model sub_osc_en");
    end
  end

  // Edge counter and pulse-width monitor
  int      edge_cnt = 0;
  realtime last_t = 0.0, min_w = 1.0e9;
  bit      last_ok = 0;
  always @(posedge cpu_clk) edge_cnt++;
  always @(cpu_clk) begin
    if (last_ok && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t  = $realtime;
    last_ok = 1;
  end

  task automatic measure(string req, int exp, string what);
    #400;
    edge_cnt = 0;
    #1600;
    check_near(req, edge_cnt, exp, what);
  endtask

  task automatic wr(input logic [5:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // bit0 sub_sel, bit1 div8, bits3:2 field, bit4 main_off, bit5 sub_en
  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    cmp_on = 1;
    cur_req = "R1";
    check("R1", int'(rd_data), 2, "reset rd_data");
    check("R1", int'(mode), 3, "reset mode");
    check("R1", int'(main_osc_en), 1, "reset main_osc_en");
    check("R1", int'(sub_osc_en), 0, "reset sub_osc_en");
    measure("R1", 20, "reset rate /8 edges");

    cur_req = "R2"; wr(6'b000000);
    check("R2", int'(mode), 0, "high mode");
    measure("R2", 160, "high rate edges");
    cur_req = "R3"; wr(6'b000100);
    check("R3", int'(mode), 1, "div2 mode");
    measure("R3", 80, "div2 edges");
    wr(6'b001000);
    check("R3", int'(mode), 2, "div4 mode");
    measure("R3", 40, "div4 edges");
    wr(6'b001100);
    check("R3", int'(mode), 4, "div16 mode");
    measure("R3", 10, "div16 edges");
    cur_req = "R4"; wr(6'b000110);
    check("R4", int'(mode), 3, "div8 with field 01 mode");
    measure("R4", 20, "div8 edges");
    wr(6'b000000);
    idle(40);

    cur_req = "R6"; sub_stable = 1'b0;
    wr(6'b100001);
    idle(20);
    check("R6", int'(mode), 0, "held on main while sub unstable");
    check("R5", int'(sub_osc_en), 1, "sub osc enabled");
    min_w = 1.0e9;
    cur_req = "R5"; sub_stable = 1'b1;
    idle(2);
    check("R5", int'(mode), 5, "low-speed mode");
    measure("R5", 27, "sub rate edges");
    check("R11", (min_w >= 4.9) ? 1 : 0, 1, "no runt on switch to sub");

    cur_req = "R10"; wr(6'b100001);
    cur_req = "R7"; wr(6'b110001);
    check("R7", int'(mode), 6, "low-power mode");
    check("R7", int'(rd_data[1]), 1, "div8 forced");
    check("R7", int'(main_osc_en), 0, "main osc stopped");
    cur_req = "R8"; wr(6'b110001);
    check("R8", int'(rd_data[1]), 1, "div8 write ignored");
    cur_req = "R9"; wr(6'b110000);
    check("R9", int'(rd_data[0]), 1, "sub_sel clear rejected");
    check("R9", int'(mode), 6, "still low-power");

    cur_req = "R7"; main_stable = 1'b0;
    wr(6'b100001);
    check("R7", int'(rd_data[1]), 1, "div8 kept on leaving low-power");
    check("R7", int'(mode), 5, "back to low-speed");
    cur_req = "R6"; wr(6'b100010);
    idle(20);
    check("R6", int'(mode), 5, "held on sub while main unstable");
    min_w = 1.0e9;
    main_stable = 1'b1;
    idle(2);
    check("R6", int'(mode), 3, "main at div8 after low-power");
    #400;
    measure("R6", 20, "return rate /8 edges");
    check("R11", (min_w >= 4.9) ? 1 : 0, 1, "no runt on switch to main");

    cur_req = "R10"; wr(6'b010000);
    check("R10", int'(rd_data[4]), 0, "main_off rejected on main clock");
    check("R10", int'(main_osc_en), 1, "main osc still on");
    check("R10", int'(mode), 0, "still high mode");
    idle(10);
    finish_run();
  end
endmodule